// File: doc/BRIEF.md
# XOR-Only Authenticated-Encryption Mode Controller

This block wraps an external 128-bit block cipher and runs an online, inverse-free authenticated-encryption mode around it. It holds one 128-bit chaining state. Every change to that state is either an XOR of caller data, a replacement of the upper half by caller data, or the cipher's output. Commands arrive one at a time on a valid/ready port. Each absorbing command updates the state and then hands it to the cipher through a start/done handshake. A 64-bit result block or the full 128-bit tag appears on registered outputs.

Decryption never needs a cipher inverse. The ciphertext command writes the incoming ciphertext into the upper half of the state, so the receiver's state follows the same path as the sender's. Each data block is handled once, in the cycle it is accepted, and is never stored. Besides the chaining state, the only storage is a busy flag and the output registers.

Command codes on `cmd_op` are 0 absorb, 1 overwrite, 2 nonce, 3 ciphertext and 4 tag. Codes 5 to 7 are undefined.

Top module: `aead_mode_ctrl`

## Requirements
- R1: After synchronous reset the state is zero, `cmd_ready` is 1, and `out_valid`, `tag_valid` and `ciph_start` are 0, so `ciph_in` reads zero.
- R2: Code 0 (absorb) XORs `cmd_data` into state bits 127:64 and keeps bits 63:0. In the next cycle `out_valid` is 1 and `out_data` is `cmd_data` XOR the old bits 127:64.
- R3: Code 1 (overwrite) replaces state bits 127:64 with `cmd_data` and keeps bits 63:0. It produces no output block.
- R4: Code 2 (nonce) XORs the 128-bit word {`cmd_nonce`, 8'hA5} into the state. It produces no output block.
- R5: Code 3 (ciphertext) gives `out_data` = `cmd_data` XOR the old bits 127:64 in the next cycle, with `out_valid` 1. It then replaces state bits 127:64 with `cmd_data`.
- R6: Code 4 (tag) gives, in the next cycle, `tag_valid` 1 for one cycle with `tag_data` equal to the full state. It starts no cipher call and leaves `cmd_ready` at 1.
- R7: Codes 0 to 3 raise `ciph_start` for exactly one cycle, in the cycle after acceptance. `cmd_ready` then stays 0 until `ciph_done` is seen. A command offered while `cmd_ready` is 0 has no effect.
- R8: While a call is pending, `ciph_in` shows the updated state. The cycle after `ciph_done`, the state holds `ciph_out` and `cmd_ready` is 1.
- R9: An accepted undefined code (5 to 7) changes no state, raises no output and starts no call.
- R10: Encrypting a message and then, from reset, replaying the same nonce and feeding the ciphertexts with code 3 recovers each plaintext block and yields the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_op | input | 3 | Command code |
| cmd_data | input | 64 | Data or ciphertext block |
| cmd_nonce | input | 120 | Nonce, used by code 2 |
| cmd_ready | output | 1 | A command can be accepted |
| out_valid | output | 1 | `out_data` holds a new block |
| out_data | output | 64 | Ciphertext or plaintext block |
| tag_valid | output | 1 | `tag_data` holds the tag |
| tag_data | output | 128 | Full state as tag |
| ciph_start | output | 1 | One-cycle cipher call request |
| ciph_in | output | 128 | Cipher input (current state) |
| ciph_done | input | 1 | Cipher result is valid |
| ciph_out | input | 128 | Cipher result |

## Verification
The assertions check the handshake rules on every cycle:
- `ciph_start` is a single-cycle pulse with `cmd_ready` low.
- The state does not move while a call is pending and no `ciph_done` has come.
- `cmd_ready` returns in the cycle after `ciph_done`.
- A tag never coincides with a cipher call, and a tag never coincides with an output block.

The XOR arithmetic of each command can only be shown by the bench's scenarios, which compare against a model state and a reversible stand-in cipher. The same holds for the placement of the nonce constant, the rejection of commands while busy and of undefined codes, and the encrypt/decrypt round trip.

// File: rtl/aead_pkg.sv
package aead_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ABSORB    = 3'd0,
    OP_OVERWRITE = 3'd1,
    OP_NONCE     = 3'd2,
    OP_CTEXT     = 3'd3,
    OP_TAG       = 3'd4
  } op_e;

  typedef struct packed {
    logic upd_xor;   // XOR block into upper half
    logic upd_copy;  // replace upper half by block
    logic upd_nonce; // XOR padded nonce into full state
    logic emit;      // produce an output block
    logic tag;       // produce the tag
    logic call;      // start a cipher call
  } dec_t;
endpackage

// File: rtl/aead_cmd_dec.sv
module aead_cmd_dec
  import aead_pkg::*;
(
  input  logic            accept,
  input  logic [OP_W-1:0] op,
  output dec_t            dec
);
  always_comb begin
    dec = '0;
    if (accept) begin
      case (op_e'(op))
        OP_ABSORB:    begin dec.upd_xor  = 1'b1; dec.emit = 1'b1; dec.call = 1'b1; end
        OP_OVERWRITE: begin dec.upd_copy = 1'b1; dec.call = 1'b1; end
        OP_NONCE:     begin dec.upd_nonce = 1'b1; dec.call = 1'b1; end
        OP_CTEXT:     begin dec.upd_copy = 1'b1; dec.emit = 1'b1; dec.call = 1'b1; end
        OP_TAG:       dec.tag = 1'b1;
        default:      dec = '0;
      endcase
    end
  end
endmodule

// File: rtl/aead_state_reg.sv
module aead_state_reg
  import aead_pkg::*;
#(
  parameter int ST_W    = 128,
  parameter int BLK_W   = 64,
  parameter int NONCE_W = 120,
  localparam int PAD_W  = ST_W - NONCE_W,
  parameter logic [PAD_W-1:0] NONCE_PAD = 8'hA5
) (
  input  logic               clk,
  input  logic               rst,
  input  dec_t               dec,
  input  logic [BLK_W-1:0]   blk,
  input  logic [NONCE_W-1:0] nonce,
  input  logic               load,
  input  logic [ST_W-1:0]    load_val,
  output logic [ST_W-1:0]    state
);
  localparam int LO_W = ST_W - BLK_W;

  logic [BLK_W-1:0] upper;
  logic [LO_W-1:0]  lower;
  assign upper = state[ST_W-1 -: BLK_W];
  assign lower = state[LO_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)
      state <= '0;
    else if (load)
      state <= load_val;
    else if (dec.upd_xor)
      state <= {upper ^ blk, lower};
    else if (dec.upd_copy)
      state <= {blk, lower};
    else if (dec.upd_nonce)
      state <= state ^ {nonce, NONCE_PAD};
  end
endmodule

// File: rtl/aead_cipher_hs.sv
module aead_cipher_hs (
  input  logic clk,
  input  logic rst,
  input  logic call,
  input  logic done,
  output logic busy,
  output logic start,
  output logic load
);
  assign load = busy & done;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      start <= 1'b0;
    end else begin
      start <= call;
      if (call)
        busy <= 1'b1;
      else if (load)
        busy <= 1'b0;
    end
  end

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    start |=> !start); // R7
endmodule

// File: rtl/aead_mode_ctrl.sv
module aead_mode_ctrl
  import aead_pkg::*;
#(
  parameter int ST_W    = 128,
  parameter int BLK_W   = 64,
  parameter int NONCE_W = 120,
  localparam int PAD_W  = ST_W - NONCE_W,
  parameter logic [PAD_W-1:0] NONCE_PAD = 8'hA5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  input  logic [OP_W-1:0]    cmd_op,
  input  logic [BLK_W-1:0]   cmd_data,
  input  logic [NONCE_W-1:0] cmd_nonce,
  output logic               cmd_ready,
  output logic               out_valid,
  output logic [BLK_W-1:0]   out_data,
  output logic               tag_valid,
  output logic [ST_W-1:0]    tag_data,
  output logic               ciph_start,
  output logic [ST_W-1:0]    ciph_in,
  input  logic               ciph_done,
  input  logic [ST_W-1:0]    ciph_out
);
  dec_t            dec;
  logic            busy;
  logic            load;
  logic [ST_W-1:0] state;

  assign cmd_ready = ~busy;
  assign ciph_in   = state;

  aead_cmd_dec u_dec (
    .accept (cmd_valid & cmd_ready),
    .op     (cmd_op),
    .dec    (dec)
  );

  aead_cipher_hs u_hs (
    .clk   (clk),
    .rst   (rst),
    .call  (dec.call),
    .done  (ciph_done),
    .busy  (busy),
    .start (ciph_start),
    .load  (load)
  );

  aead_state_reg #(
    .ST_W      (ST_W),
    .BLK_W     (BLK_W),
    .NONCE_W   (NONCE_W),
    .NONCE_PAD (NONCE_PAD)
  ) u_state (
    .clk      (clk),
    .rst      (rst),
    .dec      (dec),
    .blk      (cmd_data),
    .nonce    (cmd_nonce),
    .load     (load),
    .load_val (ciph_out),
    .state    (state)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      tag_valid <= 1'b0;
      tag_data  <= '0;
    end else begin
      out_valid <= dec.emit;
      tag_valid <= dec.tag;
      if (dec.emit)
        out_data <= cmd_data ^ state[ST_W-1 -: BLK_W];
      if (dec.tag)
        tag_data <= state;
    end
  end

  AST_START_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    ciph_start |-> !cmd_ready); // R7
  AST_STATE_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && !ciph_done) |=> $stable(state)); // R7
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (busy && ciph_done) |=> (cmd_ready && state == $past(ciph_out))); // R8
  AST_TAG_NO_CALL: assert property (@(posedge clk) disable iff (rst)
    tag_valid |-> !ciph_start); // R6
  AST_TAG_OUT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(tag_valid && out_valid)); // R2
endmodule

// File: tb/test_aead_mode_ctrl.sv
module test_aead_mode_ctrl;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic [2:0]   cmd_op = '0;
  logic [63:0]  cmd_data = '0;
  logic [119:0] cmd_nonce = '0;
  logic         cmd_ready, out_valid, tag_valid, ciph_start;
  logic [63:0]  out_data;
  logic [127:0] tag_data, ciph_in;
  logic         ciph_done = 1'b0;
  logic [127:0] ciph_out = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [127:0] model = '0;

  always #10 clk = ~clk;

  aead_mode_ctrl i_aead_mode_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_nonce(cmd_nonce), .cmd_ready(cmd_ready),
    .out_valid(out_valid), .out_data(out_data), .tag_valid(tag_valid),
    .tag_data(tag_data), .ciph_start(ciph_start), .ciph_in(ciph_in),
    .ciph_done(ciph_done), .ciph_out(ciph_out)
  );

  function automatic logic [127:0] stand_in(logic [127:0] x);
    return {x[98:0], x[127:99]} ^ 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;
  endfunction

  function automatic string req_of(logic [2:0] op);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // stand-in cipher, latency 2..5 cycles
  initial begin
    forever begin
      @(negedge clk);
      if (ciph_start) begin
        repeat (2 + ($urandom % 4)) @(negedge clk);
        ciph_out  = stand_in(ciph_in);
        ciph_done = 1'b1;
        @(negedge clk);
        ciph_done = 1'b0;
      end
    end
  end

  task automatic do_cmd(logic [2:0] op, logic [63:0] data, logic [119:0] nonce,
                        output logic [63:0] got);
    logic [127:0] old;
    logic [63:0]  exp_out;
    bit call, emit, tg;
    string rq;
    while (!cmd_ready) @(negedge clk);
    rq = req_of(op);
    old = model;
    exp_out = data ^ model[127:64];
    call = (op <= 3'd3);
    emit = (op == 3'd0) || (op == 3'd3);
    tg   = (op == 3'd4);
    case (op)
      3'd0: model[127:64] = model[127:64] ^ data;
      3'd1, 3'd3: model[127:64] = data;
      3'd2: model = model ^ {nonce, 8'hA5};
      default: ;
    endcase
    cmd_op = op; cmd_data = data; cmd_nonce = nonce; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    got = out_data;
    chk(out_valid == emit, rq, "out_valid", {127'd0, out_valid}, {127'd0, emit});
    if (emit) chk(out_data == exp_out, rq, "out_data", {64'd0, out_data}, {64'd0, exp_out});
    chk(tag_valid == tg, rq, "tag_valid", {127'd0, tag_valid}, {127'd0, tg});
    if (tg) chk(tag_data == old, rq, "tag_data", tag_data, old);
    chk(ciph_start == call, "R7", "ciph_start", {127'd0, ciph_start}, {127'd0, call});
    chk(cmd_ready == !call, "R7", "cmd_ready", {127'd0, cmd_ready}, {127'd0, !call});
    if (call) begin
      chk(ciph_in == model, rq, "state to cipher", ciph_in, model);
      model = stand_in(model);
      // command offered while busy must be dropped (R7)
      cmd_op = 3'd4; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(!tag_valid && !out_valid && !ciph_start, "R7", "busy command ignored",
          {125'd0, tag_valid, out_valid, ciph_start}, 128'd0);
      while (!cmd_ready) @(negedge clk);
      chk(ciph_in == model, "R8", "state after done", ciph_in, model);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model = '0;
    @(negedge clk);
  endtask

  initial begin
    logic [63:0]  got;
    logic [63:0]  pt [4];
    logic [63:0]  ct [4];
    logic [119:0] nc;
    logic [127:0] tag_enc;
    void'($urandom(32'h5EED));
    do_reset();
    // R1 reset state
    chk(cmd_ready && !out_valid && !tag_valid && !ciph_start, "R1", "reset flags",
        {124'd0, cmd_ready, out_valid, tag_valid, ciph_start}, 128'h8);
    chk(ciph_in == '0, "R1", "reset state", ciph_in, 128'd0);
    do_cmd(3'd4, 64'd0, 120'd0, got);                        // R6 tag of zero state
    // directed: nonce constant placement, all-ones data, undefined codes
    do_cmd(3'd2, 64'd0, 120'd0, got);                        // R4 pad only
    do_cmd(3'd4, 64'd0, 120'd0, got);
    do_cmd(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 120'd0, got);       // R2
    do_cmd(3'd1, 64'h0123_4567_89AB_CDEF, 120'd0, got);       // R3
    do_cmd(3'd3, 64'd0, 120'd0, got);                        // R5
    do_cmd(3'd5, 64'hDEAD, 120'd0, got);                     // R9
    do_cmd(3'd7, 64'hBEEF, 120'd0, got);                     // R9
    do_cmd(3'd4, 64'd0, 120'd0, got);
    // random mix of all codes
    for (int i = 0; i < 60; i++) begin
      do_cmd(3'($urandom % 8), {$urandom, $urandom},
             {$urandom, $urandom, $urandom, $urandom} >> 8, got);
    end
    do_cmd(3'd4, 64'd0, 120'd0, got);
    // R10 round trip: encrypt
    do_reset();
    nc = {$urandom, $urandom, $urandom, $urandom} >> 8;
    do_cmd(3'd2, 64'd0, nc, got);
    for (int i = 0; i < 4; i++) begin
      pt[i] = {$urandom, $urandom};
      do_cmd(3'd0, pt[i], 120'd0, got);
      ct[i] = got;
    end
    do_cmd(3'd4, 64'd0, 120'd0, got);
    tag_enc = tag_data;
    // decrypt from reset
    do_reset();
    do_cmd(3'd2, 64'd0, nc, got);
    for (int i = 0; i < 4; i++) begin
      do_cmd(3'd3, ct[i], 120'd0, got);
      chk(got == pt[i], "R10", "recovered plaintext", {64'd0, got}, {64'd0, pt[i]});
    end
    do_cmd(3'd4, 64'd0, 120'd0, got);
    chk(tag_data == tag_enc, "R10", "matching tag", tag_data, tag_enc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule